// File: doc/BRIEF.md
# PLL Clock Control Register

This block is the control register that sits in front of a clock multiplier. It holds an 8-bit control byte with two live fields: a run bit that starts the multiplier and a source bit that chooses between the multiplied clock and the raw input clock (clock-through). It also models the multiplier's settling time. A timer starts when the run bit turns on, and a lock flag rises once a programmable number of input-clock cycles has passed.

Software reaches the register in two ways. It can write the whole byte, or it can set or clear one bit in a single access. The block protects the clock mux in two ways. A request for the multiplied clock is quietly turned into clock-through while the multiplier is not locked. Switching the multiplier off pulls the source bit back to clock-through in the same write. The outputs drive the multiplier's enable and the mux select. A ratio output reports the frequency factor of the clock that is currently selected.

Top module: `clkctl_top`

## Requirements
- R1: After reset the register reads 0x01: the run bit (bit 0) is 1, the source bit (bit 1) is 0, `use_pll` is 0 and `pll_locked` is 0.
- R2: A byte access (`acc_bit`=0) loads bit 0 of `acc_wdata` into the run bit, and `pll_on` follows it after the write edge.
- R3: Any access that leaves the run bit at 0 also leaves the source bit at 0, even when that access writes 1 to bit 1.
- R4: An access that writes 1 to the source bit stores 1 only if `pll_locked` is 1 at the write edge. Otherwise it stores 0.
- R5: A single-bit access (`acc_bit`=1) writes `acc_wdata[0]` into bit `acc_idx` and leaves every other bit unchanged.
- R6: `pll_locked` rises exactly LOCK_CYCLES clock edges after the edge that turns the run bit on (or after reset is released). It falls in the same cycle the run bit reads 0.
- R7: Bits 7..2 always read 0, and writes to them have no effect.
- R8: `clk_ratio` equals PLL_MULT when `use_pll` is 1 and equals 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (reference) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register write strobe, one cycle per access |
| acc_bit | input | 1 | 1 = single-bit access, 0 = byte access |
| acc_idx | input | 3 | Bit index for a single-bit access |
| acc_wdata | input | 8 | Byte data; bit 0 is the value for a single-bit access |
| ctl_rdata | output | 8 | Current register contents |
| pll_on | output | 1 | Multiplier enable |
| use_pll | output | 1 | Mux select: 1 = multiplied clock, 0 = clock-through |
| pll_locked | output | 1 | Lock-model status |
| clk_ratio | output | $clog2(PLL_MULT+1) | Factor of the selected clock |

## Verification
Two events can fall in the same write: turning the multiplier on, and requesting the multiplied clock, for example a byte write of 0x03 while the multiplier is off. The same happens when a disable arrives together with a select request, as in 0x02. The bench provokes these cases directly. It then sweeps all 256 byte values and every bit index with idle gaps of different lengths, so that writes land before, at and after the lock edge. It judges each cycle against its own cycle-count model of the run bit, the source bit and the lock timer.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int CTL_W   = 8;
  localparam int RUN_POS = 0;
  localparam int SRC_POS = 1;

  typedef struct packed {
    logic src;
    logic run;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{src: 1'b0, run: 1'b1};

  // Byte image of the live fields; spare bits read as zero.
  function automatic logic [CTL_W-1:0] view_of(ctl_t c);
    logic [CTL_W-1:0] v;
    v          = '0;
    v[RUN_POS] = c.run;
    v[SRC_POS] = c.src;
    return v;
  endfunction

  // Candidate byte after a byte write or a single-bit write.
  function automatic logic [CTL_W-1:0] merge_access(
    logic [CTL_W-1:0] cur,
    logic             is_bit,
    logic [2:0]       idx,
    logic [CTL_W-1:0] wd
  );
    logic [CTL_W-1:0] r;
    r = cur;
    if (is_bit) r[idx] = wd[0];
    else        r      = wd;
    return r;
  endfunction

  // Apply the hardware rules: select needs run and lock.
  function automatic ctl_t resolve(logic [CTL_W-1:0] cand, logic locked);
    ctl_t n;
    n.run = cand[RUN_POS];
    n.src = cand[SRC_POS] & cand[RUN_POS] & locked;
    return n;
  endfunction

  function automatic int unsigned ratio_of(logic src, int unsigned mult);
    return src ? mult : 32'd1;
  endfunction

endpackage

// File: rtl/clkctl_lock_timer.sv
module clkctl_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;
  logic          at_term;

  assign at_term = (cnt == TERM);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!at_term) cnt <= cnt + 1'b1;
  end

  assign locked = run && at_term;
endmodule

// File: rtl/clkctl_ctl_reg.sv
module clkctl_ctl_reg
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_bit,
  input  logic [2:0]       acc_idx,
  input  logic [CTL_W-1:0] acc_wdata,
  input  logic             locked,
  output ctl_t             state,
  output logic             src_refused,
  output logic             src_forced_clear
);
  logic [CTL_W-1:0] cand;
  ctl_t             nxt;

  always_comb begin
    cand = merge_access(view_of(state), acc_bit, acc_idx, acc_wdata);
    nxt  = resolve(cand, locked);
  end

  assign src_refused      = acc_valid && cand[SRC_POS] && cand[RUN_POS] && !locked;
  assign src_forced_clear = acc_valid && !cand[RUN_POS] && state.src;

  always_ff @(posedge clk) begin
    if (!rst_n)         state <= CTL_RESET;
    else if (acc_valid) state <= nxt;
  end
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 16,
  parameter int unsigned PLL_MULT    = 8,
  localparam int RATIO_W = $clog2(PLL_MULT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_bit,
  input  logic [2:0]         acc_idx,
  input  logic [7:0]         acc_wdata,
  output logic [7:0]         ctl_rdata,
  output logic               pll_on,
  output logic               use_pll,
  output logic               pll_locked,
  output logic [RATIO_W-1:0] clk_ratio
);
  ctl_t state;
  logic src_refused;
  logic src_forced_clear;

  clkctl_ctl_reg u_reg (
    .clk              (clk),
    .rst_n            (rst_n),
    .acc_valid        (acc_valid),
    .acc_bit          (acc_bit),
    .acc_idx          (acc_idx),
    .acc_wdata        (acc_wdata),
    .locked           (pll_locked),
    .state            (state),
    .src_refused      (src_refused),
    .src_forced_clear (src_forced_clear)
  );

  clkctl_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state.run),
    .locked (pll_locked)
  );

  assign ctl_rdata = view_of(state);
  assign pll_on    = state.run;
  assign use_pll   = state.src;
  assign clk_ratio = RATIO_W'(ratio_of(state.src, PLL_MULT));
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
  parameter int unsigned PLL_MULT = 8,
  localparam int RATIO_W = $clog2(PLL_MULT + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0]         ctl_rdata,
  input logic               pll_on,
  input logic               use_pll,
  input logic               pll_locked,
  input logic [RATIO_W-1:0] clk_ratio,
  input logic               src_refused,
  input logic               src_forced_clear
);
  // R4
  refuse_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_refused |=> !use_pll);

  // R3
  forced_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_forced_clear |=> (!use_pll && !pll_on));

  // R4
  select_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_pll |-> pll_locked);

  // R6
  lock_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> (pll_on && $past(pll_on)));

  // R7
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[7:2] == 6'd0);

  // R8
  ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_pll |-> (clk_ratio == RATIO_W'(PLL_MULT)));
endmodule

bind clkctl_top clkctl_chk #(.PLL_MULT(PLL_MULT)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .ctl_rdata        (ctl_rdata),
  .pll_on           (pll_on),
  .use_pll          (use_pll),
  .pll_locked       (pll_locked),
  .clk_ratio        (clk_ratio),
  .src_refused      (src_refused),
  .src_forced_clear (src_forced_clear)
);

// File: tb/clkctl_top_test.sv
`timescale 1ns/1ps
module clkctl_top_test;
  localparam int L    = 4;
  localparam int MULT = 8;
  localparam int RW   = $clog2(MULT + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_bit = 1'b0;
  logic [2:0]    acc_idx = '0;
  logic [7:0]    acc_wdata = '0;
  logic [7:0]    ctl_rdata;
  logic          pll_on, use_pll, pll_locked;
  logic [RW-1:0] clk_ratio;

  int n_chk = 0, n_fail = 0;
  int m_on, m_src, m_cnt;

  always #4 clk = ~clk;

  clkctl_top #(.LOCK_CYCLES(L), .PLL_MULT(MULT)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_bit(acc_bit),
    .acc_idx(acc_idx), .acc_wdata(acc_wdata), .ctl_rdata(ctl_rdata),
    .pll_on(pll_on), .use_pll(use_pll), .pll_locked(pll_locked),
    .clk_ratio(clk_ratio)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_locked();
    return (m_on == 1 && m_cnt == L) ? 1 : 0;
  endfunction

  // Compare every output with the bench's own state.
  task automatic compare_all();
    check("R2 rdata", int'(ctl_rdata), m_src * 2 + m_on);
    check("R4 use_pll", int'(use_pll), m_src);
    check("R6 locked", int'(pll_locked), m_locked());
    check("R8 ratio", int'(clk_ratio), (m_src == 1) ? MULT : 1);
  endtask

  // One clock cycle, optionally carrying an access.
  task automatic cyc(input bit v, input bit b, input int idx, input int wd);
    int cand, lk;
    acc_valid = v; acc_bit = b; acc_idx = 3'(idx); acc_wdata = 8'(wd);
    @(posedge clk);
    lk = m_locked();
    if (m_on == 0) m_cnt = 0;
    else if (m_cnt != L) m_cnt = m_cnt + 1;
    if (v) begin
      cand = m_src * 2 + m_on;
      if (b) cand = wd[0] ? (cand | (1 << idx)) : (cand & ~(1 << idx));
      else   cand = wd;
      m_on  = cand & 1;
      m_src = ((cand >> 1) & 1) & m_on & lk;
    end
    @(negedge clk);
    acc_valid = 1'b0;
    compare_all();
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_on = 1; m_src = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", int'(ctl_rdata), 1);
    check("R1 use_pll", int'(use_pll), 0);
    check("R1 locked", int'(pll_locked), 0);
    rst_n = 1'b1;
    // R6 lock after reset release: exactly L edges
    for (int i = 1; i <= L; i++) begin
      cyc(0, 0, 0, 0);
      check("R6 lock edge", int'(pll_locked), (i == L) ? 1 : 0);
    end
    // R4 accepted once locked
    cyc(1, 0, 0, 8'h03);
    check("R4 accept", int'(ctl_rdata), 3);
    // R3 disable with select request clears both
    cyc(1, 0, 0, 8'h02);
    check("R3 clear", int'(ctl_rdata), 0);
    // R4 enable and select in one write: select refused
    cyc(1, 0, 0, 8'h03);
    check("R4 refuse", int'(ctl_rdata), 1);
    for (int i = 1; i <= L; i++) begin
      cyc(0, 0, 0, 0);
      check("R6 lock after enable", int'(pll_locked), (i == L) ? 1 : 0);
    end
    // R5 single-bit set of select, then R3 single-bit clear of run
    cyc(1, 1, 1, 1);
    check("R5 bit set", int'(use_pll), 1);
    cyc(1, 1, 0, 0);
    check("R3 bit clear run", int'(ctl_rdata), 0);
    check("R6 drop", int'(pll_locked), 0);
    // R7 spare bits
    cyc(1, 0, 0, 8'hFF);
    check("R7 spare", int'(ctl_rdata), 1);
    cyc(1, 1, 5, 1);
    check("R7 spare bit", int'(ctl_rdata), 1);
    // Byte sweep with varying idle gaps
    for (int d = 0; d < 256; d++) begin
      cyc(1, 0, 0, d);
      for (int g = 0; g < d % (L + 2); g++) cyc(0, 0, 0, 0);
    end
    // Single-bit sweep, R5
    for (int gap = 0; gap <= L + 1; gap++)
      for (int idx = 0; idx < 8; idx++)
        for (int val = 0; val < 2; val++) begin
          cyc(1, 1, idx, val);
          for (int g = 0; g < gap; g++) cyc(0, 0, 0, 0);
        end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule